// File: doc/BRIEF.md
# Microcoded 16-bit CPU Control Sequencer

This block is the control state machine of a small 16-bit load/store processor. It walks every instruction through a fetch sequence, latches a branch-enable flag during decode, and then jumps straight to one of sixteen execute routines. The routine is chosen by the number held in the top four instruction bits. Each state emits one control word. The word carries the register load enables, the bus gate enables, the mux selects, the ALU function and the memory enable and write strobe. The register file, ALU and memory sit outside the block and act on that word.

States live in a 6-bit number space. The control word is looked up from the next state number and registered together with it, so the word is stable for the whole of the state it belongs to. Every memory state holds until the memory reports ready. An interrupt request is examined once per instruction, in the fetch state.

Three flows are not sequenced here: return-from-interrupt, illegal opcode and interrupt entry. For these the block spends one cycle in a hand-off state. In that cycle it flags the hand-off and names the state number of the flow that takes over. It then resumes at fetch.

Top module: `cseq_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the state becomes 18 (fetch). The control word becomes the fetch word, which has only bits 0 (MAR load), 6 (PC load) and 7 (PC gate) set. That word is 0x0000C1.
- R2: In state 18, a high `irq_i` makes the next state 49 (interrupt hand-off). Otherwise the next state is 33 (instruction read).
- R3: States 33, 25, 24, 29, 28 (reads) and 16 (write) stay put while `mem_ready_i` is 0 and advance when it is 1. In these states control bit 11 (memory enable) is set. Bit 12 (write) is set in state 16 only.
- R4: Fetch runs 18 → 33 → 35 → 32. In state 32 the block latches `ben_o` = |(`ir_mode_i` & `cc_nzp_i`), where bit 2 pairs with N, bit 1 with Z and bit 0 with P. The next state equals `ir_op_i`.
- R5: State 0 goes to 22 (PC takes the 9-bit-offset sum, bit 6 set) when `ben_o` is 1. It goes to 18 when `ben_o` is 0. State 22 goes to 18.
- R6: State 4 writes R7 from the PC. It sets bit 4 (register load) and has destination select bits [22:21] = 01. It goes to 21 when `ir_mode_i[2]` is 1 and to 20 otherwise. Both 21 and 20 load PC (bit 6) and return to 18.
- R7: Indirect load runs 10 → 24 → 26 → 25 → 27 → 18. Indirect store runs 11 → 29 → 31 → 23 → 16 → 18. In states 26 and 31 the MAR is loaded from the MDR, so bits 0 and 8 are set.
- R8: Base-plus-offset load goes 6 → 25, and base-plus-offset store goes 7 → 23. Both set address-2 select bits [19:18] = 01 (6-bit offset).
- R9: Trap runs 15 → 28 → 30 → 18. State 15 loads MAR with address-mux select bit 20 = 0 (zero-extended vector). State 30 loads PC from the MDR: bits 6 and 8 are set and PC select bits [16:15] = 01.
- R10: The condition-code load (bit 5) is set together with the register load in states 1, 5, 9, 27 and 14. It is never set without the register load.
- R11: States 8, 13 and 49 raise `handoff_o` for one cycle and then go to 18. In state 8, `handoff_tgt_o` is 44 when `priv_user_i` is 1 and 36 when it is 0. In states 13 and 49 it is 45 when `priv_user_i` is 1 and 37 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_op_i | input | 4 | Instruction bits 15:12 (opcode) |
| ir_mode_i | input | 3 | Instruction bits 11:9 (branch mask / call mode) |
| cc_nzp_i | input | 3 | Condition codes N, Z, P |
| mem_ready_i | input | 1 | Memory access complete |
| irq_i | input | 1 | Interrupt request |
| priv_user_i | input | 1 | Processor runs in user mode |
| state_o | output | 6 | Current state number |
| ctrl_o | output | 24 | Registered control word |
| ben_o | output | 1 | Branch-enable flag |
| handoff_o | output | 1 | Hand-off state active |
| handoff_tgt_o | output | 6 | State number of the flow taking over |

## Verification
The fetch state does two things in the same cycle. It loads the MAR and increments the PC, and it also decides whether an interrupt diverts the sequence. The bench raises `irq_i` while the sequencer sits in state 18. It then confirms that the control word in that cycle still carries the MAR and PC loads, and that the next state is 49 and not 33. A second overlap is a memory state stalled on ready. In that case the memory enable must stay asserted while the state number stays frozen. The bench holds `mem_ready_i` low for several cycles in both a read and a write state to check this.

// File: rtl/cseq_pkg.sv
// Shared widths, state numbers and control-word bit positions of the
// control sequencer. Assumes a 6-bit state space.
package cseq_pkg;
    localparam int SW = 6;
    localparam int OPW = 4;
    localparam int CW = 24;

    typedef logic [SW-1:0] st_t;

    // fetch and decode
    localparam st_t S_FETCH  = 6'd18;
    localparam st_t S_IFRD   = 6'd33;
    localparam st_t S_LDIR   = 6'd35;
    localparam st_t S_DECODE = 6'd32;
    // routine entries (number equals opcode)
    localparam st_t S_BR   = 6'd0;
    localparam st_t S_ADD  = 6'd1;
    localparam st_t S_LD   = 6'd2;
    localparam st_t S_ST   = 6'd3;
    localparam st_t S_JSR  = 6'd4;
    localparam st_t S_AND  = 6'd5;
    localparam st_t S_LDR  = 6'd6;
    localparam st_t S_STR  = 6'd7;
    localparam st_t S_RTI  = 6'd8;
    localparam st_t S_NOT  = 6'd9;
    localparam st_t S_LDI  = 6'd10;
    localparam st_t S_STI  = 6'd11;
    localparam st_t S_JMP  = 6'd12;
    localparam st_t S_ILL  = 6'd13;
    localparam st_t S_LEA  = 6'd14;
    localparam st_t S_TRAP = 6'd15;
    // follow-on states
    localparam st_t S_WR     = 6'd16;
    localparam st_t S_JSRR   = 6'd20;
    localparam st_t S_JSRO   = 6'd21;
    localparam st_t S_BRTK   = 6'd22;
    localparam st_t S_STMDR  = 6'd23;
    localparam st_t S_LDIRD  = 6'd24;
    localparam st_t S_LDRD   = 6'd25;
    localparam st_t S_LDIPTR = 6'd26;
    localparam st_t S_LDWB   = 6'd27;
    localparam st_t S_TRRD   = 6'd28;
    localparam st_t S_STIRD  = 6'd29;
    localparam st_t S_TRPC   = 6'd30;
    localparam st_t S_STIPTR = 6'd31;
    localparam st_t S_IRQ    = 6'd49;
    // hand-off targets (sequenced elsewhere)
    localparam st_t T_RTI   = 6'd36;
    localparam st_t T_PUSH  = 6'd37;
    localparam st_t T_PRIV  = 6'd44;
    localparam st_t T_SWSTK = 6'd45;

    // control-word bit positions
    localparam int B_LD_MAR   = 0;
    localparam int B_LD_MDR   = 1;
    localparam int B_LD_IR    = 2;
    localparam int B_LD_BEN   = 3;
    localparam int B_LD_REG   = 4;
    localparam int B_LD_CC    = 5;
    localparam int B_LD_PC    = 6;
    localparam int B_G_PC     = 7;
    localparam int B_G_MDR    = 8;
    localparam int B_G_ALU    = 9;
    localparam int B_G_ADR    = 10;
    localparam int B_MEM_EN   = 11;
    localparam int B_MEM_WE   = 12;
    localparam int B_ALUK     = 13;   // 2 bits
    localparam int B_PCSEL    = 15;   // 2 bits
    localparam int B_A1SEL    = 17;
    localparam int B_A2SEL    = 18;   // 2 bits
    localparam int B_ADRSEL   = 20;
    localparam int B_DRSEL    = 21;   // 2 bits
    localparam int B_SR1SEL   = 23;

    // field codes
    localparam logic [1:0] ALU_ADD = 2'd0, ALU_AND = 2'd1, ALU_NOT = 2'd2, ALU_PASS = 2'd3;
    localparam logic [1:0] PC_INC = 2'd0, PC_BUS = 2'd1, PC_SUM = 2'd2;
    localparam logic [1:0] A2_ZERO = 2'd0, A2_OFF6 = 2'd1, A2_OFF9 = 2'd2, A2_OFF11 = 2'd3;
    localparam logic [1:0] DR_IR = 2'd0, DR_R7 = 2'd1;
endpackage

// File: rtl/cseq_next.sv
// Next-state logic of the sequencer. Purely combinational. Memory states
// hold on a low ready; the fetch state checks the interrupt request once.
// Also names the flow that takes over in hand-off states.
module cseq_next
    import cseq_pkg::*;
(
    input  st_t              state_i,
    input  logic [OPW-1:0]   ir_op_i,
    input  logic             jsr_off_i,
    input  logic             ben_i,
    input  logic             mem_ready_i,
    input  logic             irq_i,
    input  logic             priv_user_i,
    output st_t              next_o,
    output st_t              tgt_o
);
    // pick the successor of the current state
    always_comb begin
        next_o = S_FETCH;
        tgt_o  = priv_user_i ? T_SWSTK : T_PUSH;
        case (state_i)
            S_FETCH:  next_o = irq_i ? S_IRQ : S_IFRD;
            S_IFRD:   next_o = mem_ready_i ? S_LDIR : S_IFRD;
            S_LDIR:   next_o = S_DECODE;
            S_DECODE: next_o = {{(SW-OPW){1'b0}}, ir_op_i};
            S_BR:     next_o = ben_i ? S_BRTK : S_FETCH;
            S_LD:     next_o = S_LDRD;
            S_LDR:    next_o = S_LDRD;
            S_LDRD:   next_o = mem_ready_i ? S_LDWB : S_LDRD;
            S_ST:     next_o = S_STMDR;
            S_STR:    next_o = S_STMDR;
            S_STMDR:  next_o = S_WR;
            S_WR:     next_o = mem_ready_i ? S_FETCH : S_WR;
            S_JSR:    next_o = jsr_off_i ? S_JSRO : S_JSRR;
            S_LDI:    next_o = S_LDIRD;
            S_LDIRD:  next_o = mem_ready_i ? S_LDIPTR : S_LDIRD;
            S_LDIPTR: next_o = S_LDRD;
            S_STI:    next_o = S_STIRD;
            S_STIRD:  next_o = mem_ready_i ? S_STIPTR : S_STIRD;
            S_STIPTR: next_o = S_STMDR;
            S_TRAP:   next_o = S_TRRD;
            S_TRRD:   next_o = mem_ready_i ? S_TRPC : S_TRRD;
            S_RTI:    tgt_o  = priv_user_i ? T_PRIV : T_RTI;
            default:  next_o = S_FETCH;
        endcase
    end
endmodule

// File: rtl/cseq_rom.sv
// State-indexed control-word lookup. Combinational; the caller registers
// the result. Unlisted states give an all-zero (idle) word.
module cseq_rom
    import cseq_pkg::*;
(
    input  st_t            state_i,
    output logic [CW-1:0]  word_o
);
    // build the control word for the given state
    always_comb begin
        word_o = '0;
        case (state_i)
            S_FETCH: begin
                word_o[B_LD_MAR] = 1'b1; word_o[B_LD_PC] = 1'b1; word_o[B_G_PC] = 1'b1;
                word_o[B_PCSEL +: 2] = PC_INC;
            end
            S_IFRD, S_LDRD, S_LDIRD, S_STIRD, S_TRRD: begin
                word_o[B_LD_MDR] = 1'b1; word_o[B_MEM_EN] = 1'b1;
            end
            S_LDIR: begin
                word_o[B_LD_IR] = 1'b1; word_o[B_G_MDR] = 1'b1;
            end
            S_DECODE: word_o[B_LD_BEN] = 1'b1;
            S_BRTK, S_JSRO: begin
                word_o[B_LD_PC] = 1'b1; word_o[B_PCSEL +: 2] = PC_SUM;
                word_o[B_A1SEL] = 1'b0;
                word_o[B_A2SEL +: 2] = (state_i == S_BRTK) ? A2_OFF9 : A2_OFF11;
            end
            S_ADD, S_AND, S_NOT: begin
                word_o[B_LD_REG] = 1'b1; word_o[B_LD_CC] = 1'b1; word_o[B_G_ALU] = 1'b1;
                word_o[B_SR1SEL] = 1'b1; word_o[B_DRSEL +: 2] = DR_IR;
                word_o[B_ALUK +: 2] = (state_i == S_ADD) ? ALU_ADD :
                                      (state_i == S_AND) ? ALU_AND : ALU_NOT;
            end
            S_LD, S_ST, S_LDI, S_STI, S_LDR, S_STR: begin
                word_o[B_LD_MAR] = 1'b1; word_o[B_G_ADR] = 1'b1; word_o[B_ADRSEL] = 1'b1;
                if (state_i == S_LDR || state_i == S_STR) begin
                    word_o[B_A1SEL] = 1'b1; word_o[B_SR1SEL] = 1'b1;
                    word_o[B_A2SEL +: 2] = A2_OFF6;
                end else begin
                    word_o[B_A2SEL +: 2] = A2_OFF9;
                end
            end
            S_LDWB: begin
                word_o[B_LD_REG] = 1'b1; word_o[B_LD_CC] = 1'b1; word_o[B_G_MDR] = 1'b1;
            end
            S_STMDR: begin
                word_o[B_LD_MDR] = 1'b1; word_o[B_G_ALU] = 1'b1;
                word_o[B_ALUK +: 2] = ALU_PASS;
            end
            S_WR: begin
                word_o[B_MEM_EN] = 1'b1; word_o[B_MEM_WE] = 1'b1;
            end
            S_JSR: begin
                word_o[B_LD_REG] = 1'b1; word_o[B_G_PC] = 1'b1;
                word_o[B_DRSEL +: 2] = DR_R7;
            end
            S_JSRR, S_JMP: begin
                word_o[B_LD_PC] = 1'b1; word_o[B_PCSEL +: 2] = PC_SUM;
                word_o[B_A1SEL] = 1'b1; word_o[B_SR1SEL] = 1'b1;
                word_o[B_A2SEL +: 2] = A2_ZERO;
            end
            S_LDIPTR, S_STIPTR: begin
                word_o[B_LD_MAR] = 1'b1; word_o[B_G_MDR] = 1'b1;
            end
            S_LEA: begin
                word_o[B_LD_REG] = 1'b1; word_o[B_LD_CC] = 1'b1; word_o[B_G_ADR] = 1'b1;
                word_o[B_ADRSEL] = 1'b1; word_o[B_A2SEL +: 2] = A2_OFF9;
            end
            S_TRAP: begin
                word_o[B_LD_MAR] = 1'b1; word_o[B_G_ADR] = 1'b1; word_o[B_ADRSEL] = 1'b0;
            end
            S_TRPC: begin
                word_o[B_LD_PC] = 1'b1; word_o[B_G_MDR] = 1'b1;
                word_o[B_PCSEL +: 2] = PC_BUS;
            end
            default: word_o = '0;
        endcase
    end
endmodule

// File: rtl/cseq_ben.sv
// Branch-enable register. Latches the masked condition codes while the
// load strobe is high; holds otherwise. Clears on reset.
module cseq_ben (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [2:0] mask_i,
    input  logic [2:0] nzp_i,
    output logic       ben_o
);
    // capture the branch decision during decode
    always_ff @(posedge clk) begin
        if (!rst_n)      ben_o <= 1'b0;
        else if (load_i) ben_o <= |(mask_i & nzp_i);
    end
endmodule

// File: rtl/cseq_top.sv
// Control sequencer top. Registers the state number and the control word
// for that state together, so the word is stable for the whole state.
// Assumes the datapath acts on ctrl_o and reports memory completion.
module cseq_top
    import cseq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      ir_op_i,
    input  logic [2:0]      ir_mode_i,
    input  logic [2:0]      cc_nzp_i,
    input  logic            mem_ready_i,
    input  logic            irq_i,
    input  logic            priv_user_i,
    output logic [5:0]      state_o,
    output logic [23:0]     ctrl_o,
    output logic            ben_o,
    output logic            handoff_o,
    output logic [5:0]      handoff_tgt_o
);
    st_t           state_q, next_s, state_d, tgt_s;
    logic [CW-1:0] word_d, ctrl_q;
    logic          ben_s;

    cseq_next next_i (
        .state_i(state_q), .ir_op_i(ir_op_i), .jsr_off_i(ir_mode_i[2]),
        .ben_i(ben_s), .mem_ready_i(mem_ready_i), .irq_i(irq_i),
        .priv_user_i(priv_user_i), .next_o(next_s), .tgt_o(tgt_s)
    );

    // reset forces the fetch state into both registers
    always_comb state_d = rst_n ? next_s : S_FETCH;

    cseq_rom rom_i (.state_i(state_d), .word_o(word_d));

    cseq_ben ben_i (
        .clk(clk), .rst_n(rst_n), .load_i(state_q == S_DECODE),
        .mask_i(ir_mode_i), .nzp_i(cc_nzp_i), .ben_o(ben_s)
    );

    // state number and control word advance together
    always_ff @(posedge clk) begin
        state_q <= state_d;
        ctrl_q  <= word_d;
    end

    // hand-off flag for flows sequenced outside this block
    always_comb handoff_o = (state_q == S_RTI) || (state_q == S_ILL) || (state_q == S_IRQ);

    assign state_o       = state_q;
    assign ctrl_o        = ctrl_q;
    assign ben_o         = ben_s;
    assign handoff_tgt_o = tgt_s;
endmodule

// File: rtl/cseq_chk.sv
// Checker for the control sequencer, bound to cseq_top.
module cseq_chk
    import cseq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  ir_op_i,
    input logic        mem_ready_i,
    input logic        irq_i,
    input logic [5:0]  state_o,
    input logic [23:0] ctrl_o,
    input logic        handoff_o
);
    // R1
    reset_fetch_chk: assert property (@(posedge clk) !rst_n |=> state_o == S_FETCH);
    // R2
    irq_divert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_FETCH && irq_i) |=> state_o == S_IRQ);
    // R3
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o[B_MEM_EN] && !mem_ready_i) |=> $stable(state_o));
    // R3
    we_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[B_MEM_WE] |-> ctrl_o[B_MEM_EN]);
    // R4
    dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == S_DECODE |=> state_o == {2'b00, $past(ir_op_i)});
    // R10
    cc_with_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[B_LD_CC] |-> ctrl_o[B_LD_REG]);
    // R11
    handoff_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        handoff_o |=> state_o == S_FETCH);
endmodule

bind cseq_top cseq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .ir_op_i(ir_op_i), .mem_ready_i(mem_ready_i),
    .irq_i(irq_i), .state_o(state_o), .ctrl_o(ctrl_o), .handoff_o(handoff_o)
);

// File: tb/cseq_top_tb_top.sv
// Directed bench for the control sequencer: one task per scenario.
module cseq_top_tb_top;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] ir_op = '0;
    logic [2:0] ir_mode = '0, cc_nzp = '0;
    logic mem_ready = 1'b1, irq = 1'b0, priv_user = 1'b0;
    logic [5:0] state_o, tgt_o;
    logic [23:0] ctrl_o;
    logic ben_o, handoff_o;

    int n_chk = 0;
    int n_bad = 0;

    cseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .ir_op_i(ir_op), .ir_mode_i(ir_mode),
        .cc_nzp_i(cc_nzp), .mem_ready_i(mem_ready), .irq_i(irq),
        .priv_user_i(priv_user), .state_o(state_o), .ctrl_o(ctrl_o),
        .ben_o(ben_o), .handoff_o(handoff_o), .handoff_tgt_o(tgt_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq = 1'b0; mem_ready = 1'b1;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    // from state 18, run fetch and decode into the routine of op
    task automatic to_routine(input logic [3:0] op, input logic [2:0] mode, input logic [2:0] nzp);
        irq = 1'b0; mem_ready = 1'b1;
        tick(); chk("R4 fetch->33", state_o, 33);
        tick(); chk("R4 33->35", state_o, 35);
        ir_op = op; ir_mode = mode; cc_nzp = nzp;
        tick(); chk("R4 35->32", state_o, 32);
        tick(); chk("R4 dispatch", state_o, int'(op));
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tick(); tick();
        chk("R1 state", state_o, 18);
        chk("R1 word", int'(ctrl_o), 32'hC1);
        rst_n = 1'b1;
    endtask

    task automatic t_irq();
        do_reset();
        irq = 1'b1; priv_user = 1'b0;
        chk("R2 fetch word kept", int'(ctrl_o), 32'hC1);
        tick(); chk("R2 irq next", state_o, 49);
        irq = 1'b0; #1;
        chk("R11 irq handoff", int'(handoff_o), 1);
        chk("R11 irq tgt sup", tgt_o, 37);
        priv_user = 1'b1; #1;
        chk("R11 irq tgt user", tgt_o, 45);
        tick(); chk("R11 return", state_o, 18);
        priv_user = 1'b0;
        tick(); chk("R2 no irq", state_o, 33);
    endtask

    task automatic t_wait();
        do_reset();
        mem_ready = 1'b0;
        tick(); chk("R3 enter 33", state_o, 33);
        chk("R3 mem_en", int'(ctrl_o[11]), 1);
        chk("R3 no we read", int'(ctrl_o[12]), 0);
        tick(); tick(); chk("R3 hold 33", state_o, 33);
        mem_ready = 1'b1;
        tick(); chk("R3 leave 33", state_o, 35);
        do_reset();
        to_routine(4'd3, 3'd0, 3'd0);
        tick(); chk("R3 st 23", state_o, 23);
        mem_ready = 1'b0;
        tick(); chk("R3 enter 16", state_o, 16);
        chk("R3 we", int'(ctrl_o[12]), 1);
        tick(); tick(); chk("R3 hold 16", state_o, 16);
        mem_ready = 1'b1;
        tick(); chk("R3 leave 16", state_o, 18);
    endtask

    task automatic t_dispatch();
        for (int op = 0; op < 16; op++) begin
            do_reset();
            to_routine(op[3:0], 3'd0, 3'd0);
        end
    endtask

    task automatic t_branch();
        do_reset();
        to_routine(4'd0, 3'b010, 3'b010);
        chk("R4 ben set", int'(ben_o), 1);
        tick(); chk("R5 taken", state_o, 22);
        chk("R5 pc load", int'(ctrl_o[6]), 1);
        tick(); chk("R5 back", state_o, 18);
        to_routine(4'd0, 3'b100, 3'b001);
        chk("R4 ben clear", int'(ben_o), 0);
        tick(); chk("R5 not taken", state_o, 18);
    endtask

    task automatic t_jsr();
        do_reset();
        to_routine(4'd4, 3'b100, 3'd0);
        chk("R6 reg load", int'(ctrl_o[4]), 1);
        chk("R6 dr r7", int'(ctrl_o[22:21]), 1);
        chk("R10 no cc jsr", int'(ctrl_o[5]), 0);
        tick(); chk("R6 offset form", state_o, 21);
        tick(); chk("R6 back", state_o, 18);
        to_routine(4'd4, 3'b000, 3'd0);
        tick(); chk("R6 base form", state_o, 20);
        chk("R6 pc load", int'(ctrl_o[6]), 1);
        tick(); chk("R6 back2", state_o, 18);
    endtask

    task automatic t_indirect();
        do_reset();
        to_routine(4'd10, 3'd0, 3'd0);
        tick(); chk("R7 ldi 24", state_o, 24);
        tick(); chk("R7 ldi 26", state_o, 26);
        chk("R7 mar from mdr", int'({ctrl_o[8], ctrl_o[0]}), 3);
        tick(); chk("R7 ldi 25", state_o, 25);
        tick(); chk("R7 ldi 27", state_o, 27);
        chk("R10 cc ld", int'({ctrl_o[5], ctrl_o[4]}), 3);
        tick(); chk("R7 ldi end", state_o, 18);
        to_routine(4'd11, 3'd0, 3'd0);
        tick(); chk("R7 sti 29", state_o, 29);
        tick(); chk("R7 sti 31", state_o, 31);
        chk("R7 sti mar", int'({ctrl_o[8], ctrl_o[0]}), 3);
        tick(); chk("R7 sti 23", state_o, 23);
        tick(); chk("R7 sti 16", state_o, 16);
        tick(); chk("R7 sti end", state_o, 18);
    endtask

    task automatic t_base();
        do_reset();
        to_routine(4'd6, 3'd0, 3'd0);
        chk("R8 ldr off6", int'(ctrl_o[19:18]), 1);
        tick(); chk("R8 ldr 25", state_o, 25);
        do_reset();
        to_routine(4'd7, 3'd0, 3'd0);
        chk("R8 str off6", int'(ctrl_o[19:18]), 1);
        tick(); chk("R8 str 23", state_o, 23);
    endtask

    task automatic t_trap();
        do_reset();
        to_routine(4'd15, 3'd0, 3'd0);
        chk("R9 zext sel", int'({ctrl_o[20], ctrl_o[0]}), 1);
        tick(); chk("R9 28", state_o, 28);
        tick(); chk("R9 30", state_o, 30);
        chk("R9 pc from mdr", int'({ctrl_o[16:15], ctrl_o[8], ctrl_o[6]}), 7);
        tick(); chk("R9 end", state_o, 18);
    endtask

    task automatic t_cc();
        logic [3:0] ops [4] = '{4'd1, 4'd5, 4'd9, 4'd14};
        foreach (ops[i]) begin
            do_reset();
            to_routine(ops[i], 3'd0, 3'd0);
            chk("R10 cc with reg", int'({ctrl_o[5], ctrl_o[4]}), 3);
            tick(); chk("R10 back", state_o, 18);
        end
    endtask

    task automatic t_handoff();
        do_reset();
        priv_user = 1'b1;
        to_routine(4'd8, 3'd0, 3'd0);
        chk("R11 rti flag", int'(handoff_o), 1);
        chk("R11 rti user", tgt_o, 44);
        priv_user = 1'b0; #1;
        chk("R11 rti sup", tgt_o, 36);
        tick(); chk("R11 rti back", state_o, 18);
        chk("R11 flag drop", int'(handoff_o), 0);
        to_routine(4'd13, 3'd0, 3'd0);
        chk("R11 ill sup", tgt_o, 37);
        priv_user = 1'b1; #1;
        chk("R11 ill user", tgt_o, 45);
        tick(); chk("R11 ill back", state_o, 18);
        priv_user = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_irq();
        t_wait();
        t_dispatch();
        t_branch();
        t_jsr();
        t_indirect();
        t_base();
        t_trap();
        t_cc();
        t_handoff();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule